// File: doc/BRIEF.md
# Backlight Power and Dimming Sequencer

This block drives the control side of a lamp backlight inverter from a host controller. On an on request it raises the inverter supply enable and waits for the supply to settle. It then starts a low-frequency dimming PWM, waits again, and only then raises the backlight enable. On an off request it runs the same steps in reverse: backlight enable falls, the PWM stops after a hold-off, and the supply is removed last. Every wait is a parameter counted in millisecond ticks from a shared tick input.

The dimming PWM period is a parameter in clock cycles, by default a 160 Hz rate at the core clock. The duty is an 8-bit fraction of 256. Any request below a floor of about 10 percent is raised to the floor. The duty is taken only at the start of a period.

A lamp detect input is low when the lamp is healthy. It is ignored during an ignition window after the backlight turns on. After that window, a detect level that stays high for a run of ticks latches a fault. The fault powers the backlight down and blocks restart until the host drops its request and raises it again.

Top module: `bl_seq_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, supply enable, PWM, backlight enable, ready and fault are all 0.
- R2: On an on request from the off state, supply enable rises first. The PWM's first high level comes after exactly T_SUP+1 ticks are consumed with only the supply on. Backlight enable rises after exactly T_DIM+1 further ticks. Neither the PWM nor backlight enable is high when supply enable rises.
- R3: On an off request in the fully on state, backlight enable falls first. The supply falls after exactly T_BL_OFF+T_DIM_OFF+2 ticks. The PWM stays low for the last T_DIM_OFF+1 of those ticks, and backlight enable is already low in the cycle before the supply falls.
- R4: Backlight enable and the PWM are never high while supply enable is low.
- R5: A PWM period lasts PERIOD cycles and begins with a high phase of (PERIOD*duty)/256 cycles, truncated, where duty is the effective duty.
- R6: A duty request below MIN_DUTY (default 26 of 256) acts as MIN_DUTY.
- R7: The duty input is sampled only at the start of a period. A change in the middle of a period takes effect from the next period.
- R8: An off request before backlight enable rises goes straight to the PWM-stop step. Backlight enable never rises, and the supply falls after exactly T_DIM_OFF+1 ticks.
- R9: The detect input has no effect during the first T_IGN ticks of the fully on state.
- R10: After that window, a detect input high on FAULT_N consecutive ticks sets the fault flag. Backlight enable falls in the next cycle and the power-down sequence follows. A shorter run sets nothing.
- R11: The fault flag stays set, and the sequencer stays off, while the on request remains high. It clears only when the request goes low and then high again, and the power-up sequence then restarts.
- R12: The ready flag is high exactly while the sequencer is fully on (backlight enable high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bl_req_i | input | 1 | Host on (1) / off (0) request |
| duty_i | input | 8 | Dimming duty in 1/256 units |
| lamp_det_i | input | 1 | Lamp status, high means abnormal |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| sup_en_o | output | 1 | Inverter supply enable |
| dim_pwm_o | output | 1 | Dimming PWM |
| bl_on_o | output | 1 | Backlight enable |
| bl_ready_o | output | 1 | Fully on status |
| lamp_fault_o | output | 1 | Sticky lamp fault |

## Verification
The bound assertions check the ordering rules on every cycle. These are that the supply comes up with both other outputs low, that the supply goes down only after backlight enable and with the PWM already stopped, and that nothing runs without the supply. They also check that a fault drops backlight enable at once, that the fault clears only after a request, and that ready tracks backlight enable. The exact tick counts of each step, the high time of each PWM period, the duty floor, the period-boundary duty latch, the ignition window and the fault run length can only be shown by the bench's scenarios. Those scenarios count ticks and cycles at the ports.

// File: rtl/bl_seq_pkg.sv
package bl_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SUP,
        ST_DIM,
        ST_ON,
        ST_DN_BL,
        ST_DN_DIM
    } seq_state_t;

    typedef struct packed {
        logic sup;
        logic dim;
        logic bl;
    } seq_out_t;

    function automatic seq_out_t seq_decode(seq_state_t s);
        seq_out_t o;
        o.sup = (s != ST_OFF);
        o.dim = (s == ST_DIM) || (s == ST_ON) || (s == ST_DN_BL);
        o.bl  = (s == ST_ON);
        return o;
    endfunction

    function automatic logic [7:0] duty_floor(logic [7:0] d, logic [7:0] lo);
        return (d < lo) ? lo : d;
    endfunction

endpackage

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
    import bl_seq_pkg::*;
#(
    parameter int T_SUP     = 20,
    parameter int T_DIM     = 500,
    parameter int T_BL_OFF  = 250,
    parameter int T_DIM_OFF = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       fault_i,
    input  logic       tick_i,
    output seq_state_t state_o
);
    localparam int MAX_A = (T_SUP > T_DIM) ? T_SUP : T_DIM;
    localparam int MAX_B = (T_BL_OFF > T_DIM_OFF) ? T_BL_OFF : T_DIM_OFF;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXT + 1) + 1;

    seq_state_t    state, nxt;
    logic [TW-1:0] tmr, lim;
    logic          expire, stop;

    always_comb begin
        case (state)
            ST_SUP:    lim = TW'(T_SUP);
            ST_DIM:    lim = TW'(T_DIM);
            ST_DN_BL:  lim = TW'(T_BL_OFF);
            ST_DN_DIM: lim = TW'(T_DIM_OFF);
            default:   lim = '0;
        endcase
    end

    assign expire = tick_i && (tmr == lim);
    assign stop   = !req_i || fault_i;

    always_comb begin
        nxt = state;
        case (state)
            ST_OFF:    if (req_i && !fault_i) nxt = ST_SUP;
            ST_SUP:    if (stop) nxt = ST_DN_DIM; else if (expire) nxt = ST_DIM;
            ST_DIM:    if (stop) nxt = ST_DN_DIM; else if (expire) nxt = ST_ON;
            ST_ON:     if (stop) nxt = ST_DN_BL;
            ST_DN_BL:  if (expire) nxt = ST_DN_DIM;
            ST_DN_DIM: if (expire) nxt = ST_OFF;
            default:   nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) tmr <= '0;
            else if (tick_i)  tmr <= tmr + 1'b1;
        end
    end

    assign state_o = state;
endmodule

// File: rtl/bl_seq_pwm.sv
module bl_seq_pwm
    import bl_seq_pkg::*;
#(
    parameter int PERIOD   = 1562500,
    parameter int MIN_DUTY = 26
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic [7:0] duty_i,
    output logic       pwm_o
);
    localparam int CW = $clog2(PERIOD);
    localparam int PW = CW + 9;

    logic [CW-1:0] cnt;
    logic [CW:0]   high_lat, high_new;
    logic [PW-1:0] prod;
    logic [7:0]    duty_eff;

    assign duty_eff = duty_floor(duty_i, 8'(MIN_DUTY));
    assign prod     = PW'(PERIOD) * PW'(duty_eff);
    assign high_new = prod[CW+8:8];

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt      <= '0;
            high_lat <= '0;
            pwm_o    <= 1'b0;
        end else if (cnt == '0) begin
            high_lat <= high_new;
            pwm_o    <= (high_new != '0);
            cnt      <= CW'(1 % PERIOD);
        end else begin
            pwm_o <= ({1'b0, cnt} < high_lat);
            cnt   <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bl_seq_lamp.sv
module bl_seq_lamp #(
    parameter int T_IGN   = 1000,
    parameter int FAULT_N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic on_i,
    input  logic tick_i,
    input  logic det_i,
    input  logic req_i,
    output logic fault_o
);
    localparam int IW = $clog2(T_IGN + 1);
    localparam int DW = $clog2(FAULT_N + 1);

    logic [IW-1:0] ign_cnt;
    logic [DW-1:0] det_cnt;
    logic          ign_done, clr_pend;

    assign ign_done = (ign_cnt == IW'(T_IGN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ign_cnt  <= '0;
            det_cnt  <= '0;
            fault_o  <= 1'b0;
            clr_pend <= 1'b0;
        end else begin
            if (!on_i) begin
                ign_cnt <= '0;
                det_cnt <= '0;
            end else if (tick_i) begin
                if (!ign_done) ign_cnt <= ign_cnt + 1'b1;
                else if (det_i) det_cnt <= det_cnt + 1'b1;
                else            det_cnt <= '0;
            end
            if (on_i && tick_i && ign_done && det_i && det_cnt == DW'(FAULT_N - 1)) begin
                fault_o  <= 1'b1;
                clr_pend <= 1'b0;
            end else if (fault_o && !req_i) begin
                clr_pend <= 1'b1;
            end else if (clr_pend && req_i) begin
                fault_o  <= 1'b0;
                clr_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bl_seq_top.sv
module bl_seq_top
    import bl_seq_pkg::*;
#(
    parameter int PERIOD    = 1562500,
    parameter int MIN_DUTY  = 26,
    parameter int T_SUP     = 20,
    parameter int T_DIM     = 500,
    parameter int T_BL_OFF  = 250,
    parameter int T_DIM_OFF = 1,
    parameter int T_IGN     = 1000,
    parameter int FAULT_N   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bl_req_i,
    input  logic [7:0] duty_i,
    input  logic       lamp_det_i,
    input  logic       ms_tick_i,
    output logic       sup_en_o,
    output logic       dim_pwm_o,
    output logic       bl_on_o,
    output logic       bl_ready_o,
    output logic       lamp_fault_o
);
    seq_state_t state;
    seq_out_t   outs;
    logic       fault;

    bl_seq_fsm #(
        .T_SUP(T_SUP), .T_DIM(T_DIM), .T_BL_OFF(T_BL_OFF), .T_DIM_OFF(T_DIM_OFF)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_i(bl_req_i), .fault_i(fault),
        .tick_i(ms_tick_i), .state_o(state)
    );

    assign outs = seq_decode(state);

    bl_seq_pwm #(.PERIOD(PERIOD), .MIN_DUTY(MIN_DUTY)) u_pwm (
        .clk(clk), .rst(rst), .en_i(outs.dim), .duty_i(duty_i), .pwm_o(dim_pwm_o)
    );

    bl_seq_lamp #(.T_IGN(T_IGN), .FAULT_N(FAULT_N)) u_lamp (
        .clk(clk), .rst(rst), .on_i(outs.bl), .tick_i(ms_tick_i),
        .det_i(lamp_det_i), .req_i(bl_req_i), .fault_o(fault)
    );

    assign sup_en_o     = outs.sup;
    assign bl_on_o      = outs.bl;
    assign bl_ready_o   = (state == ST_ON);
    assign lamp_fault_o = fault;
endmodule

// File: rtl/bl_seq_checker.sv
module bl_seq_checker (
    input logic clk,
    input logic rst,
    input logic bl_req_i,
    input logic sup_en_o,
    input logic dim_pwm_o,
    input logic bl_on_o,
    input logic bl_ready_o,
    input logic lamp_fault_o
);
    assert_supply_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sup_en_o) |-> (!bl_on_o && !dim_pwm_o));

    assert_supply_last_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sup_en_o) |-> (!$past(bl_on_o) && !dim_pwm_o));

    assert_bl_needs_supply_R4: assert property (@(posedge clk) disable iff (rst)
        bl_on_o |-> sup_en_o);

    assert_pwm_needs_supply_R4: assert property (@(posedge clk) disable iff (rst)
        dim_pwm_o |-> sup_en_o);

    assert_fault_drops_bl_R10: assert property (@(posedge clk) disable iff (rst)
        (lamp_fault_o && bl_on_o) |=> !bl_on_o);

    assert_fault_clear_on_req_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(lamp_fault_o) |-> $past(bl_req_i));

    assert_ready_tracks_bl_R12: assert property (@(posedge clk) disable iff (rst)
        bl_ready_o == bl_on_o);
endmodule

bind bl_seq_top bl_seq_checker u_chk (
    .clk(clk), .rst(rst), .bl_req_i(bl_req_i), .sup_en_o(sup_en_o),
    .dim_pwm_o(dim_pwm_o), .bl_on_o(bl_on_o), .bl_ready_o(bl_ready_o),
    .lamp_fault_o(lamp_fault_o)
);

// File: tb/tb_bl_seq_top.sv
module tb_bl_seq_top;
    localparam int P   = 256;
    localparam int MIN = 26;
    localparam int TS  = 3;
    localparam int TD  = 5;
    localparam int TB  = 4;
    localparam int TO  = 2;
    localparam int TI  = 8;
    localparam int FN  = 4;

    logic clk = 0, rst = 1, req = 0, det = 0, tick = 0;
    logic [7:0] duty = 8'd128;
    logic sup, pwm, bl, rdy, flt;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    bl_seq_top #(.PERIOD(P), .MIN_DUTY(MIN), .T_SUP(TS), .T_DIM(TD), .T_BL_OFF(TB),
                 .T_DIM_OFF(TO), .T_IGN(TI), .FAULT_N(FN)) dut (
        .clk(clk), .rst(rst), .bl_req_i(req), .duty_i(duty), .lamp_det_i(det),
        .ms_tick_i(tick), .sup_en_o(sup), .dim_pwm_o(pwm), .bl_on_o(bl),
        .bl_ready_o(rdy), .lamp_fault_o(flt));

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick = 1;
            @(posedge clk);
            #1 tick = 0;
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic int exp_high(input int d);
        int e = (d < MIN) ? MIN : d;
        return (P * e) / 256;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int k);
        int c = 0;
        while (c < k) begin
            if (tick) c++;
            step();
        end
    endtask

    task automatic power_up();
        int n = 0;
        req = 1;
        while (!sup) step();
        while (!pwm) begin
            if (tick) n++;
            if (bl) chk(0, "R2 bl before pwm", 1, 0);
            step();
        end
        chk(n == TS + 1, "R2 supply-to-pwm ticks", n, TS + 1);
        n = 0;
        while (!bl) begin
            if (tick) n++;
            step();
        end
        chk(n == TD + 1, "R2 pwm-to-bl ticks", n, TD + 1);
        chk(rdy == 1, "R12 ready when on", rdy, 1);
    endtask

    task automatic power_down();
        int n = 0, lastp = 0;
        req = 0;
        step();
        chk(bl == 0, "R3 bl falls first", bl, 0);
        chk(rdy == 0, "R12 ready low", rdy, 0);
        while (sup) begin
            if (pwm) lastp = 0;
            else if (tick) lastp++;
            if (tick) n++;
            step();
        end
        chk(n == TB + TO + 2, "R3 bl-to-supply ticks", n, TB + TO + 2);
        chk(lastp >= TO + 1, "R3 pwm stopped before supply", lastp, TO + 1);
    endtask

    task automatic measure(output int h);
        logic prev = pwm;
        step();
        while (!(pwm && !prev)) begin
            prev = pwm;
            step();
        end
        h = 0;
        for (int i = 0; i < P; i++) begin
            if (pwm) h++;
            step();
        end
    endtask

    initial begin
        int h, n, d0, d1;
        void'($urandom(32'd4242));
        repeat (4) step();
        chk({sup, pwm, bl, rdy, flt} == 5'b0, "R1 reset outputs", {sup, pwm, bl, rdy, flt}, 0);
        rst = 0;
        step();
        chk({sup, pwm, bl, rdy, flt} == 5'b0, "R1 after reset", {sup, pwm, bl, rdy, flt}, 0);

        // R2, R5, R6: power up, then a mix of directed and random duties
        duty = 8'd128;
        power_up();
        foreach (d0_list[i]) begin
            duty = d0_list[i];
            repeat (P + 2) step();
            measure(h);
            chk(h == exp_high(d0_list[i]), "R5/R6 directed duty", h, exp_high(d0_list[i]));
        end
        for (int i = 0; i < 14; i++) begin
            d0 = $urandom_range(0, 255);
            duty = 8'(d0);
            repeat (P + 2) step();
            measure(h);
            chk(h == exp_high(d0), (d0 < MIN) ? "R6 random duty" : "R5 random duty", h, exp_high(d0));
        end

        // R7: change mid-period
        d0 = 200; d1 = 60;
        duty = 8'(d0);
        repeat (P + 2) step();
        begin
            logic prev = pwm;
            step();
            while (!(pwm && !prev)) begin prev = pwm; step(); end
            h = 0;
            for (int i = 0; i < P; i++) begin
                if (pwm) h++;
                if (i == 10) duty = 8'(d1);
                step();
            end
        end
        chk(h == exp_high(d0), "R7 current period keeps old duty", h, exp_high(d0));
        measure(h);
        chk(h == exp_high(d1), "R7 next period uses new duty", h, exp_high(d1));

        duty = 8'd255;
        power_down();

        // R8: abort in supply wait
        req = 1;
        while (!sup) step();
        wait_ticks(1);
        req = 0;
        step();
        n = 0;
        while (sup) begin
            if (tick) n++;
            if (pwm || bl) chk(0, "R8 no pwm/bl on abort", 1, 0);
            step();
        end
        chk(n == TO + 1, "R8 abort in supply wait", n, TO + 1);

        // R8: abort in pwm wait
        repeat (3) step();
        req = 1;
        while (!pwm) step();
        req = 0;
        step();
        n = 0;
        while (sup) begin
            if (tick) n++;
            if (bl) chk(0, "R8 bl on abort", 1, 0);
            step();
        end
        chk(n == TO + 1, "R8 abort in pwm wait", n, TO + 1);

        // R9: detect ignored during ignition
        repeat (3) step();
        power_up();
        det = 1;
        wait_ticks(TI - 1);
        det = 0;
        wait_ticks(8);
        chk(flt == 0 && rdy == 1, "R9 ignition window ignores detect", flt, 0);

        // R10: short run does nothing
        det = 1;
        n = 0;
        while (n < FN - 1) begin
            if (tick) n++;
            step();
        end
        det = 0;
        wait_ticks(4);
        chk(flt == 0 && bl == 1, "R10 short detect run no fault", flt, 0);

        // R10: long run faults and powers down
        det = 1;
        n = 0;
        while (!flt && n < 200) begin n++; step(); end
        chk(flt == 1, "R10 fault set", flt, 1);
        step();
        chk(bl == 0, "R10 bl drops on fault", bl, 0);
        while (sup) step();
        det = 0;
        wait_ticks(20);
        chk(sup == 0 && flt == 1, "R11 stays off with request high", {sup, flt}, 1);
        req = 0;
        repeat (8) step();
        chk(flt == 1, "R11 fault held after off request", flt, 1);
        req = 1;
        n = 0;
        while (!sup && n < 50) begin n++; step(); end
        chk(flt == 0 && sup == 1, "R11 cleared and restarted", {flt, sup}, 1);
        while (!bl) step();
        duty = 8'd255;
        power_down();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    logic [7:0] d0_list [4] = '{8'd0, 8'd25, 8'd26, 8'd255};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule